// File: doc/BRIEF.md
# Branch and Stack Control Sequencer

This block carries out the control-transfer and stack-handling instructions of a small 8-bit processor core. Instruction fetch and decode happen elsewhere. The sequencer receives the following, all sampled on a single start pulse:

- the decoded instruction class
- the 3-bit condition or restart field
- the four condition flags
- the current program counter (already pointing past the instruction), the stack pointer and HL
- a register-pair word
- the 16-bit target operand

It then runs the byte accesses the instruction needs on a byte-wide memory port. When the instruction is finished it raises a one-cycle done pulse and presents the new program counter, stack pointer, HL and register-pair values.

The stack grows downward. A push stores the high byte at SP-1 and then the low byte at SP-2. A pop reads the low byte at SP and then the high byte at SP+1. Multi-byte values in memory are little-endian. Conditional forms test one flag chosen by the condition field and touch no memory when the test fails. Restart vectors are the restart field times eight.

The status word (accumulator plus flag byte) is pushed and popped through the register-pair path. The caller packs it with the accumulator as the high byte and the flag byte as the low byte.

The memory port is a request stream with valid/ready handshaking:

- A request consists of the valid, write-enable, address and write-data outputs.
- A byte moves on a clock edge where both valid and ready are high.
- The memory may hold ready low for any number of cycles. During that time the sequencer keeps valid high and the address, write-enable and write data unchanged.
- Read data must be valid in the cycle in which ready is high.

Top module: `ctl_xfer_seq`

## Requirements
- R1: The condition field selects one flag and a polarity: 000 zero flag clear, 001 zero flag set, 010 carry clear, 011 carry set, 100 parity flag clear, 101 parity flag set, 110 sign flag clear, 111 sign flag set.
- R2: Class 0 (jump) sets the new PC to the target. Class 1 (conditional jump) does so only when the condition holds, otherwise the new PC is the incoming PC. Neither class makes a memory access.
- R3: Class 2 (call) writes the incoming PC high byte to SP-1 and then its low byte to SP-2. It returns SP-2 and sets the new PC to the target. Class 3 (conditional call) behaves the same way when its condition holds.
- R4: A conditional class (1, 3 or 5) whose condition fails makes no memory access. It returns the incoming PC and SP unchanged, and done follows one cycle after start.
- R5: Class 4 (return) reads the low byte at SP and then the high byte at SP+1. The new PC is that word and the new SP is SP+2. Class 5 (conditional return) does so only when its condition holds.
- R6: Class 6 (restart) pushes the incoming PC exactly as a call does and sets the new PC to the condition field times 8.
- R7: Class 7 sets the new PC to HL (high byte from H, low byte from L) with no memory access.
- R8: Class 8 (push) stores the pair-input high byte at SP-1 and then its low byte at SP-2, returning SP-2. Class 9 (pop) reads the low byte at SP and the high byte at SP+1 into the pair output, returning SP+2. The status word uses these classes with the accumulator in the high byte.
- R9: Class 10 (exchange) reads SP and then SP+1, writes L to SP and then H to SP+1, and returns the old stack word as the new HL. SP is unchanged.
- R10: All stack address and SP arithmetic wraps modulo 65536.
- R11: While valid is high and ready is low, valid stays high and the address, write-enable and write data stay stable. A byte moves only on an edge with both valid and ready high.
- R12: Done is a single-cycle pulse one cycle after the final handshake, or one cycle after start for classes with no access. Busy is high from the cycle after an accepted start through the done cycle. A start while busy is ignored.
- R13: The result outputs hold their values from done until the next accepted start. Class codes 11 to 15 complete with no access and return PC, SP, HL and pair unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction; the inputs below are sampled with it |
| op | input | 4 | Instruction class code |
| cond | input | 3 | Condition or restart field |
| flag_z | input | 1 | Zero flag |
| flag_cy | input | 1 | Carry flag |
| flag_p | input | 1 | Parity flag |
| flag_s | input | 1 | Sign flag |
| pc_in | input | 16 | Address of the next instruction |
| sp_in | input | 16 | Stack pointer |
| hl_in | input | 16 | HL pair |
| pair_in | input | 16 | Pair to push (status word: accumulator high) |
| target | input | 16 | Jump or call target |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction finished, results valid |
| pc_out | output | 16 | New program counter |
| sp_out | output | 16 | New stack pointer |
| hl_out | output | 16 | New HL |
| pair_out | output | 16 | Popped pair or pair_in |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with ready |

## Verification
The bench builds the block with its default byte width of 8 and restart spacing of 8, giving 16-bit addresses. At that size every corner can be driven directly:

- every condition code with the selected flag both set and clear, and the other flags opposite;
- all eight restart vectors;
- stack pointers of 0x0000, 0x0001 and 0xFFFF, which make the push, pop and exchange addresses wrap.

The memory model answers reads with a byte computed from the address and inserts pseudo-random ready stalls. This lets the bench compute every access order, popped word and stall hold arithmetically.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [3:0] {
    XOP_JMP      = 4'd0,
    XOP_JMP_IF   = 4'd1,
    XOP_CALL     = 4'd2,
    XOP_CALL_IF  = 4'd3,
    XOP_RET      = 4'd4,
    XOP_RET_IF   = 4'd5,
    XOP_RST      = 4'd6,
    XOP_PC_HL    = 4'd7,
    XOP_PUSH     = 4'd8,
    XOP_POP      = 4'd9,
    XOP_SWAP_TOP = 4'd10
  } xop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_FIN  = 2'd2
  } xstate_e;

  function automatic logic is_push_kind(input logic [3:0] o);
    return (o == XOP_CALL) || (o == XOP_CALL_IF) || (o == XOP_RST) || (o == XOP_PUSH);
  endfunction

  function automatic logic is_pop_kind(input logic [3:0] o);
    return (o == XOP_RET) || (o == XOP_RET_IF) || (o == XOP_POP);
  endfunction

  function automatic logic is_conditional(input logic [3:0] o);
    return (o == XOP_JMP_IF) || (o == XOP_CALL_IF) || (o == XOP_RET_IF);
  endfunction

endpackage

// File: rtl/xfer_cond_eval.sv
module xfer_cond_eval (
  input  logic [2:0] cond,
  input  logic       flag_z,
  input  logic       flag_cy,
  input  logic       flag_p,
  input  logic       flag_s,
  output logic       hit
);
  logic picked;

  // upper two bits choose the flag, bit 0 is the wanted value
  always_comb begin
    unique case (cond[2:1])
      2'd0:    picked = flag_z;
      2'd1:    picked = flag_cy;
      2'd2:    picked = flag_p;
      default: picked = flag_s;
    endcase
    hit = (picked == cond[0]);
  end
endmodule

// File: rtl/xfer_access_plan.sv
module xfer_access_plan
  import xfer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]      op,
  input  logic [1:0]      step,
  input  logic [2*DW-1:0] sp0,
  input  logic [2*DW-1:0] word,
  output logic [2*DW-1:0] addr,
  output logic            we,
  output logic [DW-1:0]   wdata,
  output logic            last
);
  localparam int AW = 2 * DW;

  logic [DW-1:0] hi_b, lo_b;
  assign hi_b = word[AW-1:DW];
  assign lo_b = word[DW-1:0];

  always_comb begin
    addr  = sp0;
    we    = 1'b0;
    wdata = '0;
    last  = 1'b1;
    if (is_push_kind(op)) begin
      we = 1'b1;
      if (step == 2'd0) begin
        addr  = sp0 - AW'(1);
        wdata = hi_b;
        last  = 1'b0;
      end else begin
        addr  = sp0 - AW'(2);
        wdata = lo_b;
      end
    end else if (is_pop_kind(op)) begin
      if (step == 2'd0) begin
        last = 1'b0;
      end else begin
        addr = sp0 + AW'(1);
      end
    end else if (op == XOP_SWAP_TOP) begin
      unique case (step)
        2'd0: last = 1'b0;
        2'd1: begin
          addr = sp0 + AW'(1);
          last = 1'b0;
        end
        2'd2: begin
          we    = 1'b1;
          wdata = lo_b;
          last  = 1'b0;
        end
        default: begin
          we    = 1'b1;
          addr  = sp0 + AW'(1);
          wdata = hi_b;
        end
      endcase
    end
  end
endmodule

// File: rtl/ctl_xfer_seq.sv
module ctl_xfer_seq
  import xfer_pkg::*;
#(
  parameter int DW       = 8,
  parameter int RST_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       op,
  input  logic [2:0]       cond,
  input  logic             flag_z,
  input  logic             flag_cy,
  input  logic             flag_p,
  input  logic             flag_s,
  input  logic [2*DW-1:0]  pc_in,
  input  logic [2*DW-1:0]  sp_in,
  input  logic [2*DW-1:0]  hl_in,
  input  logic [2*DW-1:0]  pair_in,
  input  logic [2*DW-1:0]  target,
  output logic             busy,
  output logic             done,
  output logic [2*DW-1:0]  pc_out,
  output logic [2*DW-1:0]  sp_out,
  output logic [2*DW-1:0]  hl_out,
  output logic [2*DW-1:0]  pair_out,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [2*DW-1:0]  mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);
  localparam int AW = 2 * DW;

  xstate_e       state_q;
  logic [3:0]    op_q;
  logic          take_q;
  logic [AW-1:0] pc_q, sp_q, hl_q, pair_q, tgt_q, vec_q;
  logic [1:0]    step_q;
  logic [DW-1:0] lo_q, hi_q;

  logic          cond_hit;
  logic          take_now;
  logic          needs_mem;
  logic [AW-1:0] push_word;
  logic          plan_last;
  logic [AW-1:0] popped;

  xfer_cond_eval u_cond (
    .cond    (cond),
    .flag_z  (flag_z),
    .flag_cy (flag_cy),
    .flag_p  (flag_p),
    .flag_s  (flag_s),
    .hit     (cond_hit)
  );

  assign take_now  = is_conditional(op) ? cond_hit : 1'b1;
  assign needs_mem = take_now &&
                     (is_push_kind(op) || is_pop_kind(op) || (op == XOP_SWAP_TOP));

  always_comb begin
    if (op_q == XOP_PUSH)          push_word = pair_q;
    else if (op_q == XOP_SWAP_TOP) push_word = hl_q;
    else                           push_word = pc_q;
  end

  xfer_access_plan #(.DW(DW)) u_plan (
    .op    (op_q),
    .step  (step_q),
    .sp0   (sp_q),
    .word  (push_word),
    .addr  (mem_addr),
    .we    (mem_we),
    .wdata (mem_wdata),
    .last  (plan_last)
  );

  assign mem_valid = (state_q == ST_MEM);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign popped    = {hi_q, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= 4'hF;
      take_q  <= 1'b0;
      pc_q    <= '0;
      sp_q    <= '0;
      hl_q    <= '0;
      pair_q  <= '0;
      tgt_q   <= '0;
      vec_q   <= '0;
      step_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            op_q    <= op;
            take_q  <= take_now;
            pc_q    <= pc_in;
            sp_q    <= sp_in;
            hl_q    <= hl_in;
            pair_q  <= pair_in;
            tgt_q   <= target;
            vec_q   <= AW'(cond) * AW'(RST_STEP);
            step_q  <= '0;
            state_q <= needs_mem ? ST_MEM : ST_FIN;
          end
        end
        ST_MEM: begin
          if (mem_ready) begin
            if (!mem_we) begin
              if (step_q[0]) hi_q <= mem_rdata;
              else           lo_q <= mem_rdata;
            end
            if (plan_last) state_q <= ST_FIN;
            else           step_q  <= step_q + 2'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pc_out   = pc_q;
    sp_out   = sp_q;
    hl_out   = hl_q;
    pair_out = pair_q;
    if (take_q) begin
      unique case (op_q)
        XOP_JMP, XOP_JMP_IF, XOP_CALL, XOP_CALL_IF: pc_out = tgt_q;
        XOP_RET, XOP_RET_IF:                        pc_out = popped;
        XOP_RST:                                    pc_out = vec_q;
        XOP_PC_HL:                                  pc_out = hl_q;
        XOP_POP:                                    pair_out = popped;
        XOP_SWAP_TOP:                               hl_out = popped;
        default: ;
      endcase
      if (is_push_kind(op_q))     sp_out = sp_q - AW'(2);
      else if (is_pop_kind(op_q)) sp_out = sp_q + AW'(2);
    end
  end

  // R11: a stalled request is held unchanged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R12: done lasts one cycle and the block is idle after it
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R12: memory requests only while busy and before done
  p_mem_in_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy && !done);

  // R13: results hold while idle with no start
  p_hold_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(pc_out) && $stable(sp_out) && $stable(hl_out) && $stable(pair_out));

endmodule

// File: tb/ctl_xfer_seq_test.sv
module ctl_xfer_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [2:0]  cond = 3'd0;
  logic        flag_z = 1'b0, flag_cy = 1'b0, flag_p = 1'b0, flag_s = 1'b0;
  logic [15:0] pc_in = '0, sp_in = '0, hl_in = '0, pair_in = '0, target = '0;
  logic        busy, done;
  logic [15:0] pc_out, sp_out, hl_out, pair_out;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  ctl_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond(cond),
    .flag_z(flag_z), .flag_cy(flag_cy), .flag_p(flag_p), .flag_s(flag_s),
    .pc_in(pc_in), .sp_in(sp_in), .hl_in(hl_in), .pair_in(pair_in), .target(target),
    .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out), .hl_out(hl_out),
    .pair_out(pair_out), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_rdata = rdf(mem_addr);

  // memory responder with logging and stall checking
  logic [15:0] la [0:7];
  logic        lw [0:7];
  logic [7:0]  ld [0:7];
  int          log_n = 0;
  bit          wait_mode = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  bit          stalled = 1'b0;
  logic [15:0] s_addr;
  logic        s_we;
  logic [7:0]  s_wd;

  always @(negedge clk) begin
    if (stalled) begin
      chk(mem_valid === 1'b1, "R11", "valid dropped in stall", {31'd0, mem_valid}, 32'd1);
      chk(mem_addr === s_addr && mem_we === s_we && mem_wdata === s_wd, "R11",
          "request changed in stall", {8'd0, mem_addr, mem_wdata}, {8'd0, s_addr, s_wd});
    end
    stalled = 1'b0;
    mem_ready = 1'b0;
    if (mem_valid === 1'b1) begin
      mem_ready = wait_mode ? lfsr[0] : 1'b1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (mem_ready) begin
        if (log_n < 8) begin
          la[log_n] = mem_addr;
          lw[log_n] = mem_we;
          ld[log_n] = mem_wdata;
        end
        log_n++;
      end else begin
        stalled = 1'b1;
        s_addr = mem_addr;
        s_we = mem_we;
        s_wd = mem_wdata;
      end
    end
  end

  function automatic logic flag_of(input logic [3:0] fl, input logic [1:0] sel);
    case (sel)
      2'd0: return fl[2];
      2'd1: return fl[0];
      2'd2: return fl[1];
      default: return fl[3];
    endcase
  endfunction

  // fl = {s, z, p, cy}
  task automatic do_case(input logic [3:0] o, input logic [2:0] c, input logic [3:0] fl,
                         input logic [15:0] pc, input logic [15:0] sp, input logic [15:0] hl,
                         input logic [15:0] pr, input logic [15:0] tg, input bit poke,
                         input string tag);
    logic        taken;
    logic [15:0] epc, esp, ehl, epr, w, v;
    logic [15:0] ea [0:3];
    logic        ew [0:3];
    logic [7:0]  ed [0:3];
    int          n, cyc;
    taken = (o == 4'd1 || o == 4'd3 || o == 4'd5) ? (flag_of(fl, c[2:1]) == c[0]) : 1'b1;
    epc = pc; esp = sp; ehl = hl; epr = pr; n = 0;
    for (int i = 0; i < 4; i++) begin ea[i] = '0; ew[i] = 1'b0; ed[i] = '0; end
    v = {rdf(sp + 16'd1), rdf(sp)};
    case (o)
      4'd0: epc = tg;
      4'd1: if (taken) epc = tg;
      4'd2, 4'd3, 4'd6, 4'd8: if (taken) begin
        w = (o == 4'd8) ? pr : pc;
        n = 2;
        ea[0] = sp - 16'd1; ew[0] = 1'b1; ed[0] = w[15:8];
        ea[1] = sp - 16'd2; ew[1] = 1'b1; ed[1] = w[7:0];
        esp = sp - 16'd2;
        if (o == 4'd6) epc = {13'd0, c} * 16'd8;
        else if (o != 4'd8) epc = tg;
      end
      4'd4, 4'd5, 4'd9: if (taken) begin
        n = 2;
        ea[0] = sp; ea[1] = sp + 16'd1;
        esp = sp + 16'd2;
        if (o == 4'd9) epr = v; else epc = v;
      end
      4'd7: epc = hl;
      4'd10: begin
        n = 4;
        ea[0] = sp; ea[1] = sp + 16'd1;
        ea[2] = sp; ew[2] = 1'b1; ed[2] = hl[7:0];
        ea[3] = sp + 16'd1; ew[3] = 1'b1; ed[3] = hl[15:8];
        ehl = v;
      end
      default: ;
    endcase

    @(negedge clk);
    op = o; cond = c; {flag_s, flag_z, flag_p, flag_cy} = fl;
    pc_in = pc; sp_in = sp; hl_in = hl; pair_in = pr; target = tg;
    log_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(busy === 1'b1, "R12", "busy after start", {31'd0, busy}, 32'd1);
    if (poke && !done) begin
      op = 4'd7; hl_in = 16'hDEAD; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    while (done !== 1'b1 && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(done === 1'b1, tag, "done seen", {31'd0, done}, 32'd1);
    chk(pc_out === epc, tag, "pc_out", {16'd0, pc_out}, {16'd0, epc});
    chk(sp_out === esp, tag, "sp_out", {16'd0, sp_out}, {16'd0, esp});
    chk(hl_out === ehl, tag, "hl_out", {16'd0, hl_out}, {16'd0, ehl});
    chk(pair_out === epr, tag, "pair_out", {16'd0, pair_out}, {16'd0, epr});
    chk(log_n == n, tag, "access count", log_n, n);
    for (int i = 0; i < 4; i++) begin
      if (i < n && i < log_n) begin
        chk(la[i] === ea[i], tag, $sformatf("addr of access %0d", i), {16'd0, la[i]}, {16'd0, ea[i]});
        chk(lw[i] === ew[i], tag, $sformatf("dir of access %0d", i), {31'd0, lw[i]}, {31'd0, ew[i]});
        if (ew[i])
          chk(ld[i] === ed[i], tag, $sformatf("data of access %0d", i), {24'd0, ld[i]}, {24'd0, ed[i]});
      end
    end
    if (n == 0) chk(cyc == 1, "R12", "no-access latency", cyc, 1);
    else if (!wait_mode && !poke) chk(cyc == n + 1, "R12", "zero-wait latency", cyc, n + 1);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R12", "done single pulse", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    int fails_at_end;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_valid === 1'b0, "R12", "reset state",
        {29'd0, busy, done, mem_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    do_case(4'd0, 3'd0, 4'h0, 16'h1234, 16'h8000, 16'h0, 16'h0, 16'hBEEF, 0, "R2");
    for (int c = 0; c < 8; c++) begin
      for (int val = 0; val < 2; val++) begin
        logic [3:0] fl;
        fl = val[0] ? 4'h0 : 4'hF;
        case (c / 2)
          0: fl[2] = val[0];
          1: fl[0] = val[0];
          2: fl[1] = val[0];
          default: fl[3] = val[0];
        endcase
        do_case(4'd1, c[2:0], fl, 16'h2000 + 16'(c), 16'h9000, 16'h0, 16'h0, 16'h4321, 0, "R1");
        do_case(4'd3, c[2:0], fl, 16'h3100, 16'h9000 + 16'(c), 16'h0, 16'h0, 16'h0777, 0, "R3");
        do_case(4'd5, c[2:0], fl, 16'h5555, 16'h7000 + 16'(c * 3), 16'h0, 16'h0, 16'h0, 0, "R5");
      end
    end
    do_case(4'd1, 3'd1, 4'h0, 16'h0101, 16'h4000, 16'h0, 16'h0, 16'hAAAA, 0, "R4");
    do_case(4'd3, 3'd3, 4'h0, 16'h0202, 16'h4000, 16'h0, 16'h0, 16'hAAAA, 0, "R4");
    do_case(4'd5, 3'd0, 4'h4, 16'h0303, 16'h4000, 16'h0, 16'h0, 16'h0, 0, "R4");
    do_case(4'd2, 3'd0, 4'h0, 16'hC3A7, 16'hF000, 16'h0, 16'h0, 16'h1000, 0, "R3");
    do_case(4'd4, 3'd0, 4'h0, 16'h0, 16'h1F00, 16'h0, 16'h0, 16'h0, 0, "R5");
    for (int c = 0; c < 8; c++)
      do_case(4'd6, c[2:0], 4'h0, 16'h6000 + 16'(c), 16'hE000, 16'h0, 16'h0, 16'h0, 0, "R6");
    do_case(4'd7, 3'd0, 4'h0, 16'h0, 16'h1111, 16'hABCD, 16'h0, 16'h0, 0, "R7");
    do_case(4'd8, 3'd0, 4'h0, 16'h0, 16'hD000, 16'h0, 16'h8A1C, 16'h0, 0, "R8");
    do_case(4'd9, 3'd0, 4'h0, 16'h0, 16'hD000, 16'h0, 16'h1234, 16'h0, 0, "R8");
    do_case(4'd10, 3'd0, 4'h0, 16'h0, 16'hC800, 16'h5A3C, 16'h0, 16'h0, 0, "R9");
    do_case(4'd2, 3'd0, 4'h0, 16'h1357, 16'h0001, 16'h0, 16'h0, 16'h2000, 0, "R10");
    do_case(4'd8, 3'd0, 4'h0, 16'h0, 16'h0000, 16'h0, 16'hF00D, 16'h0, 0, "R10");
    do_case(4'd9, 3'd0, 4'h0, 16'h0, 16'hFFFF, 16'h0, 16'h0, 16'h0, 0, "R10");
    do_case(4'd10, 3'd0, 4'h0, 16'h0, 16'hFFFF, 16'h9876, 16'h0, 16'h0, 0, "R10");
    do_case(4'd4, 3'd0, 4'h0, 16'h0, 16'hFFFE, 16'h0, 16'h0, 16'h0, 0, "R10");

    wait_mode = 1'b1;
    do_case(4'd10, 3'd0, 4'h0, 16'h0, 16'h3000, 16'h0F1E, 16'h0, 16'h0, 0, "R11");
    do_case(4'd6, 3'd5, 4'h0, 16'h7777, 16'h3000, 16'h0, 16'h0, 16'h0, 0, "R11");
    do_case(4'd9, 3'd0, 4'h0, 16'h0, 16'h3456, 16'h0, 16'h0, 16'h0, 0, "R11");
    do_case(4'd8, 3'd0, 4'h0, 16'h0, 16'h2222, 16'h0, 16'h3344, 16'h0, 1, "R12");
    wait_mode = 1'b0;
    do_case(4'd10, 3'd0, 4'h0, 16'h0, 16'h2400, 16'h1122, 16'h0, 16'h0, 1, "R12");

    for (int u = 11; u < 16; u++)
      do_case(4'(u), 3'd7, 4'hF, 16'h4444, 16'h5555, 16'h6666, 16'h7777, 16'h8888, 0, "R13");
    do_case(4'd4, 3'd0, 4'h0, 16'h0, 16'h6000, 16'h0, 16'h0, 16'h0, 0, "R13");
    begin
      logic [15:0] hp, hs;
      hp = pc_out; hs = sp_out;
      op = 4'd0; target = 16'h0BAD; sp_in = 16'h0;
      repeat (4) @(negedge clk);
      chk(pc_out === hp && sp_out === hs, "R13", "results held while idle",
          {pc_out, sp_out}, {hp, hs});
    end

    fails_at_end = n_fail;
    $display("[TB] %0d tests run, %0d failed", n_chk, fails_at_end);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog run did not finish actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule